// File: doc/BRIEF.md
# Rotating History Frame Buffer Manager

This block sits in front of a pixel-by-pixel background classifier. It owns four history frame memories and one background memory, all sharing one pixel address space. Pixels arrive as a stream with a valid strobe and a start-of-frame marker. The block counts addresses inside each frame. It fills the history banks during a start-up phase and, once detection is running, returns for every pixel the four stored history values and the stored background value at that address.

The first four frames go into history banks 0, 1, 2 and 3 in that order. The fourth frame is also copied into the background bank so that a model exists before detection starts. Detection begins with the first pixel of the fifth frame. For each detection pixel the memories are read in the cycle the pixel is accepted. The values appear one cycle later, and at the end of that cycle the pixel overwrites the oldest history bank. Frames are never moved between banks. Instead a rotating oldest-bank pointer selects which bank receives the write. The classifier returns the updated background value one cycle after the read data, and the block writes it back to the background bank at the same address.

The block also gates the classifier's foreground flag with an initialisation-complete status, so no foreground decision leaves the block before the history is full.

Top module: `hist_frame_rotator`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid`, `upd_take` and `init_done` are low until the conditions below set them.
- R2: The first four frames after reset are written, one per frame, into history banks 0, 1, 2 and 3 in arrival order. Bank b appears on `hist_rd_data[b*PIX_W +: PIX_W]`.
- R3: Every pixel of the fourth frame is also written into the background bank at its address, so the first detection read of an address returns that fourth-frame pixel as `bg_rd_data`.
- R4: From the first pixel of the fifth frame onward, each accepted pixel raises `rd_valid` in the next cycle. In that cycle `hist_rd_data` holds all four banks and `bg_rd_data` holds the background bank at the pixel's address, as they were before this pixel's own writes. No read is reported before that.
- R5: Each detection pixel overwrites its address in the oldest bank at the end of the cycle in which `rd_valid` is high. The first detection frame writes bank 0, and the oldest-bank pointer advances by one, modulo 4, on every later start-of-frame.
- R6: `upd_take` is high exactly two cycles after a detection pixel is accepted. The `bg_upd_data` value present in that cycle is written into the background bank at that pixel's address.
- R7: `init_done` rises in the cycle after the start-of-frame of the fifth frame is accepted and never falls afterwards. `fg_out` equals `fg_in` AND `init_done` combinationally.
- R8: A pixel is accepted only when `pix_valid` is high. A pixel with `pix_sof` high takes address 0, and each later accepted pixel takes the next address. Pixels arriving before the first start-of-frame, pixels beyond `FRAME_PIX` in one frame, and a `pix_sof` pulse with `pix_valid` low are all ignored and change no memory.
- R9: A start-of-frame may follow the last pixel of the previous frame in the very next cycle. Writes still in flight keep the bank and address captured when their pixel was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel strobe |
| pix_sof | input | 1 | First pixel of a frame (qualified by pix_valid) |
| pix_data | input | PIX_W | Current pixel value |
| bg_upd_data | input | PIX_W | Updated background value, taken while upd_take is high |
| fg_in | input | 1 | Raw foreground flag from the classifier |
| hist_rd_data | output | N_HIST*PIX_W | History bank read data, bank b in slice b |
| bg_rd_data | output | PIX_W | Background bank read data |
| rd_valid | output | 1 | Read data belongs to a detection pixel |
| upd_take | output | 1 | bg_upd_data is written this cycle |
| init_done | output | 1 | History filled, detection running |
| fg_out | output | 1 | Foreground flag masked by init_done |

## Verification
Two functions can fall in the same clock. At the very first pixel after a frame boundary, the history write of the previous frame's last pixel lands in the same cycle as the next frame's start-of-frame moves the oldest-bank pointer. The bench drives frames back to back to provoke this and judges it by the values read out a full frame later. The background write-back of that last pixel can also coincide with the new frame's first read. The bench compares every output on every clock against a behavioural model that holds the banks as integer arrays, so a write steered to the rotated bank or to a stale address shows up as a data mismatch one frame later.

// File: rtl/hfr_pkg.sv
package hfr_pkg;

   // Role of an accepted pixel, decided in the cycle it arrives.
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,   // no frame started yet
      PH_FILL   = 2'd1,   // start-up frame, history write only
      PH_SEED   = 2'd2,   // last start-up frame, history + background write
      PH_DETECT = 2'd3    // read all banks, replace oldest, write back model
   } pix_phase_e;

   // Modulo increment used for the oldest-bank pointer.
   function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/hfr_sdp_bank.sv
module hfr_sdp_bank #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned DEPTH   = 64,
   parameter bit          RD_HOLD = 1'b1,
   localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    wa,
   input  logic [WIDTH-1:0] wd,
   input  logic             re,
   input  logic [AW-1:0]    ra,
   output logic [WIDTH-1:0] rd
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   generate
      if (RD_HOLD) begin : g_hold
         // read register keeps its value between reads
         always_ff @(posedge clk) begin
            if (re) rd <= mem[ra];
         end
      end else begin : g_free
         // read register follows the address every cycle
         always_ff @(posedge clk) begin
            rd <= mem[ra];
         end
      end
   endgenerate

endmodule

// File: rtl/hfr_addr_ctl.sv
module hfr_addr_ctl #(
   parameter int unsigned FRAME_PIX = 64,
   localparam int unsigned CNT_W    = $clog2(FRAME_PIX + 1),
   localparam int unsigned MEM_AW   = $clog2(FRAME_PIX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_valid,
   input  logic              pix_sof,
   output logic              accept,
   output logic [MEM_AW-1:0] addr_s0
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_PIX);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] cnt_nx;

   always_comb begin
      base   = (pix_valid && pix_sof) ? '0 : cnt_q;
      accept = pix_valid && (base < LIMIT);
      cnt_nx = accept ? base + 1'b1 : cnt_q;
      addr_s0 = base[MEM_AW-1:0];
   end

   // Starts saturated: nothing is accepted before the first start-of-frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= LIMIT;
      else        cnt_q <= cnt_nx;
   end

endmodule

// File: rtl/hfr_seq.sv
module hfr_seq
   import hfr_pkg::*;
#(
   parameter int unsigned N_HIST = 4,
   localparam int unsigned BANK_W = $clog2(N_HIST),
   localparam int unsigned FILL_W = $clog2(N_HIST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_valid,
   input  logic              pix_sof,
   output pix_phase_e        phase_s0,
   output logic [BANK_W-1:0] bank_s0,
   output logic [BANK_W-1:0] oldest_ptr,
   output logic              init_done
);

   localparam logic [FILL_W-1:0] FULL = FILL_W'(N_HIST);
   localparam logic [FILL_W-1:0] LAST = FILL_W'(N_HIST - 1);

   logic [FILL_W-1:0] fill_q;
   logic [BANK_W-1:0] ptr_q;
   logic              done_q;
   logic              sof_evt;
   logic [BANK_W-1:0] ptr_rot;

   assign sof_evt = pix_valid && pix_sof;
   assign ptr_rot = BANK_W'(wrap_inc(int'(ptr_q), N_HIST));

   always_comb begin
      bank_s0  = ptr_q;
      phase_s0 = PH_IDLE;
      if (sof_evt) begin
         if (done_q) begin
            bank_s0  = ptr_rot;
            phase_s0 = PH_DETECT;
         end else if (fill_q == FULL) begin
            bank_s0  = '0;
            phase_s0 = PH_DETECT;
         end else begin
            bank_s0  = fill_q[BANK_W-1:0];
            phase_s0 = (fill_q == LAST) ? PH_SEED : PH_FILL;
         end
      end else if (done_q) begin
         phase_s0 = PH_DETECT;
      end else if (fill_q == FULL) begin
         phase_s0 = PH_SEED;
      end else if (fill_q != '0) begin
         phase_s0 = PH_FILL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
         ptr_q  <= '0;
         done_q <= 1'b0;
      end else if (sof_evt) begin
         ptr_q <= bank_s0;
         if (!done_q) begin
            if (fill_q == FULL) done_q <= 1'b1;
            else                fill_q <= fill_q + 1'b1;
         end
      end
   end

   assign oldest_ptr = ptr_q;
   assign init_done  = done_q;

endmodule

// File: rtl/hist_frame_rotator.sv
module hist_frame_rotator
   import hfr_pkg::*;
#(
   parameter int unsigned PIX_W     = 8,
   parameter int unsigned FRAME_PIX = 64,
   parameter int unsigned N_HIST    = 4,
   parameter bit          RD_HOLD   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pix_valid,
   input  logic                      pix_sof,
   input  logic [PIX_W-1:0]          pix_data,
   input  logic [PIX_W-1:0]          bg_upd_data,
   input  logic                      fg_in,
   output logic [N_HIST*PIX_W-1:0]   hist_rd_data,
   output logic [PIX_W-1:0]          bg_rd_data,
   output logic                      rd_valid,
   output logic                      upd_take,
   output logic                      init_done,
   output logic                      fg_out
);

   localparam int unsigned MEM_AW = $clog2(FRAME_PIX);
   localparam int unsigned BANK_W = $clog2(N_HIST);

   generate
      if (N_HIST < 2)    begin : g_bad_hist  $error("N_HIST must be at least 2");    end
      if (FRAME_PIX < 4) begin : g_bad_frame $error("FRAME_PIX must be at least 4"); end
      if (PIX_W < 1)     begin : g_bad_width $error("PIX_W must be at least 1");     end
   endgenerate

   // ---------------- stage 0: acceptance and role ----------------
   logic              accept;
   logic [MEM_AW-1:0] addr_s0;
   pix_phase_e        phase_s0;
   logic [BANK_W-1:0] bank_s0;
   logic [BANK_W-1:0] oldest_ptr;
   logic              rd_en;

   hfr_addr_ctl #(.FRAME_PIX(FRAME_PIX)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_valid (pix_valid),
      .pix_sof   (pix_sof),
      .accept    (accept),
      .addr_s0   (addr_s0)
   );

   hfr_seq #(.N_HIST(N_HIST)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pix_valid  (pix_valid),
      .pix_sof    (pix_sof),
      .phase_s0   (phase_s0),
      .bank_s0    (bank_s0),
      .oldest_ptr (oldest_ptr),
      .init_done  (init_done)
   );

   assign rd_en = accept && (phase_s0 == PH_DETECT);

   // ---------------- stage 1: data out, history write ----------------
   logic              s1_v;
   logic              s1_det;
   logic              s1_seed;
   logic [MEM_AW-1:0] s1_addr;
   logic [BANK_W-1:0] s1_bank;
   logic [PIX_W-1:0]  s1_pix;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_det  <= 1'b0;
         s1_seed <= 1'b0;
         s1_addr <= '0;
         s1_bank <= '0;
         s1_pix  <= '0;
      end else begin
         s1_v    <= accept;
         s1_det  <= rd_en;
         s1_seed <= accept && (phase_s0 == PH_SEED);
         if (accept) begin
            s1_addr <= addr_s0;
            s1_bank <= bank_s0;
            s1_pix  <= pix_data;
         end
      end
   end

   // ---------------- stage 2: background write-back ----------------
   logic              s2_v;
   logic [MEM_AW-1:0] s2_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v    <= 1'b0;
         s2_addr <= '0;
      end else begin
         s2_v <= s1_det;
         if (s1_det) s2_addr <= s1_addr;
      end
   end

   // ---------------- memories ----------------
   logic [N_HIST-1:0] hist_we;
   logic [PIX_W-1:0]  hist_rd [N_HIST];
   logic              seed_we;
   logic              bg_we;
   logic [MEM_AW-1:0] bg_wa;
   logic [PIX_W-1:0]  bg_wd;

   generate
      for (genvar b = 0; b < N_HIST; b++) begin : g_hist
         assign hist_we[b] = s1_v && (s1_bank == BANK_W'(b));

         hfr_sdp_bank #(.WIDTH(PIX_W), .DEPTH(FRAME_PIX), .RD_HOLD(RD_HOLD)) u_bank (
            .clk (clk),
            .we  (hist_we[b]),
            .wa  (s1_addr),
            .wd  (s1_pix),
            .re  (rd_en),
            .ra  (addr_s0),
            .rd  (hist_rd[b])
         );

         assign hist_rd_data[b*PIX_W +: PIX_W] = hist_rd[b];
      end
   endgenerate

   // Seeding and write-back never overlap in time; write-back wins the mux.
   assign seed_we = s1_v && s1_seed;
   assign bg_we   = seed_we || s2_v;
   assign bg_wa   = s2_v ? s2_addr : s1_addr;
   assign bg_wd   = s2_v ? bg_upd_data : s1_pix;

   hfr_sdp_bank #(.WIDTH(PIX_W), .DEPTH(FRAME_PIX), .RD_HOLD(RD_HOLD)) u_bg (
      .clk (clk),
      .we  (bg_we),
      .wa  (bg_wa),
      .wd  (bg_wd),
      .re  (rd_en),
      .ra  (addr_s0),
      .rd  (bg_rd_data)
   );

   // ---------------- outputs ----------------
   assign rd_valid = s1_det;
   assign upd_take = s2_v;
   assign fg_out   = fg_in && init_done;

endmodule

// File: rtl/hfr_checker.sv
module hfr_checker #(
   parameter int unsigned N_HIST = 4,
   parameter int unsigned BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_valid,
   input logic              pix_sof,
   input logic              rd_valid,
   input logic              upd_take,
   input logic              init_done,
   input logic              fg_out,
   input logic              seed_we,
   input logic [N_HIST-1:0] hist_we,
   input logic [BANK_W-1:0] oldest_ptr
);

   // R7: once running, the block never returns to start-up
   a_r7_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R4: no read is reported before the history is full
   a_r4_rd_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> init_done);

   // R6: a write-back slot always follows a read one cycle earlier
   a_r6_upd_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
      upd_take |-> $past(rd_valid));

   // R5: at most one history bank is written per cycle
   a_r5_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hist_we));

   // R3: seeding and write-back never compete for the background port
   a_r3_bg_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(seed_we && upd_take));

   // R5: the oldest-bank pointer moves only at a start-of-frame
   a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_valid && pix_sof) |=> $stable(oldest_ptr));

   // R7: foreground is masked until running
   a_r7_fg_mask: assert property (@(posedge clk) disable iff (!rst_n)
      fg_out |-> init_done);

endmodule

bind hist_frame_rotator hfr_checker #(.N_HIST(N_HIST), .BANK_W(BANK_W)) u_hfr_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_valid  (pix_valid),
   .pix_sof    (pix_sof),
   .rd_valid   (rd_valid),
   .upd_take   (upd_take),
   .init_done  (init_done),
   .fg_out     (fg_out),
   .seed_we    (seed_we),
   .hist_we    (hist_we),
   .oldest_ptr (oldest_ptr)
);

// File: tb/hist_frame_rotator_bench.sv
module hist_frame_rotator_bench;

   localparam int W  = 8;
   localparam int FP = 12;
   localparam int NH = 4;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pix_valid = 1'b0;
   logic            pix_sof = 1'b0;
   logic [W-1:0]    pix_data = '0;
   logic [W-1:0]    bg_upd_data = '0;
   logic            fg_in = 1'b0;
   logic [NH*W-1:0] hist_rd_data;
   logic [W-1:0]    bg_rd_data;
   logic            rd_valid, upd_take, init_done, fg_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   hist_frame_rotator #(.PIX_W(W), .FRAME_PIX(FP), .N_HIST(NH)) u_hist_frame_rotator (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
      .pix_data(pix_data), .bg_upd_data(bg_upd_data), .fg_in(fg_in),
      .hist_rd_data(hist_rd_data), .bg_rd_data(bg_rd_data), .rd_valid(rd_valid),
      .upd_take(upd_take), .init_done(init_done), .fg_out(fg_out));

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   string tag = "";

   // reference model state
   int m_hist [NH][FP];
   int m_bg [FP];
   int m_fill = 0;
   int m_bank = 0;
   int m_addr = FP;
   bit m_done = 1'b0;

   // expectations, ring indexed by cycle
   bit e_rv [4];
   int e_hist [4][NH];
   int e_bg [4];
   bit e_up [4];
   int e_upa [4];
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s %s: actual %0d expected %0d (cycle %0d)", req, tag, what, act, exp, cyc);
      end
   endtask

   task automatic step(input bit v, input bit s, input int p);
      int sl, ph, bg_v;
      bit acc;
      @(negedge clk);
      sl = cyc % 4;
      chk(rd_valid == e_rv[sl], "R4", "rd_valid", int'(rd_valid), int'(e_rv[sl]));
      chk(upd_take == e_up[sl], "R6", "upd_take", int'(upd_take), int'(e_up[sl]));
      chk(init_done == m_done, "R7", "init_done", int'(init_done), int'(m_done));
      if (e_rv[sl] && rd_valid) begin
         for (int b = 0; b < NH; b++)
            chk(int'(hist_rd_data[b*W +: W]) == e_hist[sl][b], "R2 R5", $sformatf("bank%0d", b),
                int'(hist_rd_data[b*W +: W]), e_hist[sl][b]);
         chk(int'(bg_rd_data) == e_bg[sl], "R3 R6", "background", int'(bg_rd_data), e_bg[sl]);
      end
      bg_v = int'($urandom_range(0, 255));
      bg_upd_data = W'(bg_v);
      if (e_up[sl]) m_bg[e_upa[sl]] = bg_v;
      e_rv[sl] = 1'b0;
      e_up[sl] = 1'b0;
      fg_in = 1'(($urandom_range(0, 1)));
      #1;
      chk(fg_out == (fg_in && m_done), "R7", "fg_out", int'(fg_out), int'(fg_in && m_done));
      pix_valid = v;
      pix_sof   = s;
      pix_data  = W'(p);
      // model: 0 fill, 1 seed, 2 detect
      acc = 1'b0;
      ph  = 0;
      if (v && s) begin
         m_addr = 0;
         acc = 1'b1;
         if (m_done) begin m_bank = (m_bank + 1) % NH; ph = 2; end
         else if (m_fill == NH) begin m_bank = 0; m_done = 1'b1; ph = 2; end
         else begin m_bank = m_fill; m_fill++; ph = (m_fill == NH) ? 1 : 0; end
      end else if (v && m_addr < FP) begin
         acc = 1'b1;
         ph = m_done ? 2 : ((m_fill == NH) ? 1 : 0);
      end
      if (acc) begin
         if (ph == 2) begin
            e_rv[(cyc + 1) % 4] = 1'b1;
            for (int b = 0; b < NH; b++) e_hist[(cyc + 1) % 4][b] = m_hist[b][m_addr];
            e_bg[(cyc + 1) % 4] = m_bg[m_addr];
            e_up[(cyc + 2) % 4] = 1'b1;
            e_upa[(cyc + 2) % 4] = m_addr;
         end
         m_hist[m_bank][m_addr] = p;
         if (ph == 1) m_bg[m_addr] = p;
         m_addr++;
      end
      cyc++;
   endtask

   task automatic send_frame(input int n, input bit gaps);
      for (int k = 0; k < n; k++) begin
         if (gaps && (k % 3 == 1)) step(1'b0, (k % 2 == 1), int'($urandom_range(0, 255)));
         step(1'b1, (k == 0), int'($urandom_range(0, 255)));
      end
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin e_rv[i] = 1'b0; e_up[i] = 1'b0; end
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(rd_valid == 1'b0, "R1", "rd_valid in reset", int'(rd_valid), 0);
      chk(upd_take == 1'b0, "R1", "upd_take in reset", int'(upd_take), 0);
      chk(init_done == 1'b0, "R1", "init_done in reset", int'(init_done), 0);
      rst_n = 1'b1;
      // R8: stray pixels before any start-of-frame, and a sof without valid
      tag = "R8_prelude";
      step(1'b1, 1'b0, 11);
      step(1'b0, 1'b1, 12);
      step(1'b1, 1'b0, 13);
      // R2 R3: start-up frames
      tag = "init";
      send_frame(FP, 1'b0);
      send_frame(FP, 1'b1);
      send_frame(FP, 1'b0);
      send_frame(FP, 1'b1);
      step(1'b0, 1'b0, 0);
      // R4 R5 R6: detection frames
      tag = "detect";
      send_frame(FP, 1'b1);
      // R9: frames back to back, sof right after last pixel
      tag = "R9_back_to_back";
      send_frame(FP, 1'b0);
      send_frame(FP, 1'b0);
      send_frame(FP, 1'b0);
      // R8: pixels beyond the frame size are dropped
      tag = "R8_overrun";
      send_frame(FP + 5, 1'b0);
      send_frame(FP, 1'b1);
      // short frame then full frame
      tag = "R8_short";
      send_frame(FP - 5, 1'b0);
      send_frame(FP, 1'b0);
      tag = "wrap";
      send_frame(FP, 1'b1);
      send_frame(FP, 1'b0);
      send_frame(FP, 1'b0);
      tag = "flush";
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule